// File: doc/BRIEF.md
# DTMF Digital Tone Synthesizer

This block turns a 4-bit keypad code into two digital sine sample streams, one for the low-frequency (row) group and one for the high-frequency (column) group. It runs from a free-running 3.579545 MHz reference. Each tone period is cut into 32 equal segments. A segment divider sets the segment length in whole reference cycles, chosen from the row or column selected by the latched code, and so sets the tone frequency. Each time the divider expires, a 5-bit phase counter steps through a 32-entry signed sine table.

A pulse on the load input latches a new code. The pulse also restarts both phase counters and both dividers, so every burst begins at phase zero. The block gives a signed row sample, a signed column sample and their sum, which is one bit wider than either sample. An output enable mutes all three outputs while the counters keep running. A single-tone mode passes only the row tone or only the column tone. Digital-to-analog conversion, mixing gain, filtering and pre-emphasis are left to downstream logic.

Top module: `dtmf_synth`

## Requirements
- R1: The latched code picks a (row, column) pair. Codes 1..9 give rows 0,0,0,1,1,1,2,2,2 and columns 0,1,2,0,1,2,0,1,2. Code 10 (digit 0) gives row 3, column 1. Code 11 (*) gives row 3, column 0. Code 12 (#) gives row 3, column 2. Codes 13, 14, 15 and 0 (A, B, C, D) give rows 0, 1, 2, 3 with column 3.
- R2: Row segment lengths are 160, 146, 132 and 118 reference cycles for rows 0..3. These give about 699, 766, 847 and 948 Hz.
- R3: Column segment lengths are 92, 84, 76 and 68 cycles for columns 0..3. These give about 1216, 1332, 1472 and 1645 Hz.
- R4: The phase counter steps by exactly one, modulo 32, on the clock edge that closes each segment. A full tone period is therefore 32 segments.
- R5: Phase p outputs round(127*sin(2*pi*p/32)) as a signed 8-bit value (0, 25, 49, 71, 90, 106, 117, 125, 127 for p = 0..8, mirrored and negated for the rest of the period).
- R6: A load pulse latches code_i on that clock edge. It also resets both phase counters to 0 and restarts both dividers, so the first phase step comes a full segment length later.
- R7: While tone_en_i is 0, all three sample outputs are 0. The dividers and phase counters keep running, so re-enabling resumes at the current phase with no start-up delay.
- R8: With single_i = 1, col_sel_i = 0 passes only the row tone and col_sel_i = 1 passes only the column tone. The other sample output reads 0 and the sum equals the passed tone.
- R9: sum_o is the exact 9-bit signed sum of the two (gated) samples and never wraps.
- R10: After reset the latched code is 0 (row 3, column 3), both phases are 0, all outputs read 0, and the dividers start as if that code had just been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 3.579545 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_i | input | 4 | Keypad code to latch |
| code_load_i | input | 1 | Latch code_i and restart both tones |
| tone_en_i | input | 1 | 1 enables the sample outputs |
| single_i | input | 1 | 1 selects single-tone mode |
| col_sel_i | input | 1 | In single-tone mode: 0 row, 1 column |
| row_sample_o | output | 8 | Signed row-tone sample |
| col_sample_o | output | 8 | Signed column-tone sample |
| sum_o | output | 9 | Signed sum of the two samples |

## Verification
The samples are a combinational function of registered phase counters. After a load edge, each output therefore keeps phase 0 for exactly one segment length and changes on the edge that ends it. The bench counts clock edges since the last load or reset release. It derives the expected phase as that count divided by the segment length, modulo 32, and compares all outputs at the falling edge. Each segment boundary is probed one cycle before and on the edge where it falls. The enable and single-tone controls act without a register, so their checks sample at the same falling edge at which the controls change.

// File: rtl/dtmf_synth_pkg.sv
package dtmf_synth_pkg;
  localparam int CODE_W   = 4;
  localparam int PHASE_W  = 5;
  localparam int SAMPLE_W = 8;
  localparam int SUM_W    = SAMPLE_W + 1;
  localparam int DIV_W    = 8;
  localparam int IDX_W    = 2;
  localparam int N_GROUPS = 2;

  typedef logic [IDX_W-1:0]           tone_idx_t;
  typedef logic [PHASE_W-1:0]         phase_t;
  typedef logic signed [SAMPLE_W-1:0] sample_t;

  // code 0 (digit D) maps to row 3 / column 3
  localparam tone_idx_t RST_IDX = 2'd3;

  // reference cycles per segment; grp 0 = row, 1 = column
  function automatic logic [DIV_W-1:0] seg_len(input logic grp, input tone_idx_t idx);
    case ({grp, idx})
      3'b000:  return 8'd160;
      3'b001:  return 8'd146;
      3'b010:  return 8'd132;
      3'b011:  return 8'd118;
      3'b100:  return 8'd92;
      3'b101:  return 8'd84;
      3'b110:  return 8'd76;
      default: return 8'd68;
    endcase
  endfunction

  // quarter-wave folded sine, amplitude 127
  function automatic sample_t sine_at(input phase_t ph);
    logic [3:0] k;
    logic [3:0] mag;
    sample_t    v;
    k   = ph[3:0];
    mag = (k > 4'd8) ? 4'(5'd16 - {1'b0, k}) : k;
    case (mag)
      4'd0:    v = 8'sd0;
      4'd1:    v = 8'sd25;
      4'd2:    v = 8'sd49;
      4'd3:    v = 8'sd71;
      4'd4:    v = 8'sd90;
      4'd5:    v = 8'sd106;
      4'd6:    v = 8'sd117;
      4'd7:    v = 8'sd125;
      4'd8:    v = 8'sd127;
      default: v = 8'sd0;
    endcase
    return ph[PHASE_W-1] ? -v : v;
  endfunction
endpackage

// File: rtl/dtmf_code_map.sv
module dtmf_code_map
  import dtmf_synth_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output tone_idx_t         row_idx_o,
  output tone_idx_t         col_idx_o
);
  logic [CODE_W-1:0] n;

  always_comb begin
    n = code_i - 4'd1;
    row_idx_o = 2'd3;
    col_idx_o = 2'd3;
    if (code_i >= 4'd1 && code_i <= 4'd9) begin
      row_idx_o = IDX_W'(n / 4'd3);
      col_idx_o = IDX_W'(n % 4'd3);
    end else begin
      case (code_i)
        4'd10:   begin row_idx_o = 2'd3; col_idx_o = 2'd1; end
        4'd11:   begin row_idx_o = 2'd3; col_idx_o = 2'd0; end
        4'd12:   begin row_idx_o = 2'd3; col_idx_o = 2'd2; end
        4'd13:   begin row_idx_o = 2'd0; col_idx_o = 2'd3; end
        4'd14:   begin row_idx_o = 2'd1; col_idx_o = 2'd3; end
        4'd15:   begin row_idx_o = 2'd2; col_idx_o = 2'd3; end
        default: begin row_idx_o = 2'd3; col_idx_o = 2'd3; end
      endcase
    end
  end
endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
  import dtmf_synth_pkg::*;
#(
  parameter bit        GRP     = 1'b0,
  parameter tone_idx_t RST_SEL = RST_IDX
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  tone_idx_t idx_i,
  output phase_t    phase_o,
  output sample_t   sample_o
);
  localparam logic [DIV_W-1:0] RST_CNT = seg_len(GRP, RST_SEL) - 8'd1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] reload;
  phase_t           phase_q;

  assign reload = seg_len(GRP, idx_i) - 8'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= RST_CNT;
      phase_q <= '0;
    end else if (load_i) begin
      div_q   <= reload;
      phase_q <= '0;
    end else if (div_q == '0) begin
      div_q   <= reload;
      phase_q <= phase_q + 5'd1;
    end else begin
      div_q   <= div_q - 8'd1;
    end
  end

  assign phase_o  = phase_q;
  assign sample_o = sine_at(phase_q);
endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_synth_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [3:0]                 code_i,
  input  logic                       code_load_i,
  input  logic                       tone_en_i,
  input  logic                       single_i,
  input  logic                       col_sel_i,
  output logic signed [7:0]          row_sample_o,
  output logic signed [7:0]          col_sample_o,
  output logic signed [8:0]          sum_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_sel;
  tone_idx_t         row_idx;
  tone_idx_t         col_idx;
  tone_idx_t         idx   [N_GROUPS];
  phase_t            phase [N_GROUPS];
  sample_t           raw   [N_GROUPS];
  phase_t            row_phase;
  phase_t            col_phase;
  logic              row_on;
  logic              col_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          code_q <= '0;
    else if (code_load_i) code_q <= code_i;
  end

  // reload must see the new code on the load edge itself
  assign code_sel = code_load_i ? code_i : code_q;

  dtmf_code_map u_map (
    .code_i    (code_sel),
    .row_idx_o (row_idx),
    .col_idx_o (col_idx)
  );

  assign idx[0] = row_idx;
  assign idx[1] = col_idx;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_tone
    dtmf_tone_gen #(
      .GRP     (g == 1),
      .RST_SEL (RST_IDX)
    ) u_gen (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (code_load_i),
      .idx_i    (idx[g]),
      .phase_o  (phase[g]),
      .sample_o (raw[g])
    );
  end

  assign row_phase = phase[0];
  assign col_phase = phase[1];

  assign row_on = tone_en_i && !(single_i &&  col_sel_i);
  assign col_on = tone_en_i && !(single_i && !col_sel_i);

  assign row_sample_o = row_on ? raw[0] : '0;
  assign col_sample_o = col_on ? raw[1] : '0;
  assign sum_o        = SUM_W'(row_sample_o) + SUM_W'(col_sample_o);
endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk
  import dtmf_synth_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                code_load_i,
  input logic                tone_en_i,
  input logic                single_i,
  input logic                col_sel_i,
  input phase_t              row_phase_i,
  input phase_t              col_phase_i,
  input logic signed [7:0]   row_sample_i,
  input logic signed [7:0]   col_sample_i,
  input logic signed [8:0]   sum_i
);
  assert_mute_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tone_en_i |-> (row_sample_i == 0 && col_sample_i == 0 && sum_i == 0));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_i == ({row_sample_i[7], row_sample_i} + {col_sample_i[7], col_sample_i}));

  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_load_i |=> (row_phase_i == '0 && col_phase_i == '0));

  assert_row_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(code_load_i) && row_phase_i != $past(row_phase_i))
      |-> row_phase_i == 5'($past(row_phase_i) + 5'd1));

  assert_col_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(code_load_i) && col_phase_i != $past(col_phase_i))
      |-> col_phase_i == 5'($past(col_phase_i) + 5'd1));

  assert_row_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_en_i && single_i && !col_sel_i) |-> col_sample_i == 0);

  assert_col_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_en_i && single_i && col_sel_i) |-> row_sample_i == 0);
endmodule

bind dtmf_synth dtmf_synth_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .code_load_i  (code_load_i),
  .tone_en_i    (tone_en_i),
  .single_i     (single_i),
  .col_sel_i    (col_sel_i),
  .row_phase_i  (row_phase),
  .col_phase_i  (col_phase),
  .row_sample_i (row_sample_o),
  .col_sample_i (col_sample_o),
  .sum_i        (sum_o)
);

// File: tb/dtmf_synth_tb.sv
`timescale 1ns/1ps
module dtmf_synth_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        code = '0;
  logic              load = 1'b0;
  logic              en = 1'b1;
  logic              single = 1'b0;
  logic              csel = 1'b0;
  logic signed [7:0] row_s;
  logic signed [7:0] col_s;
  logic signed [8:0] sum_s;

  int n_vec  = 0;
  int n_fail = 0;
  int t      = 0;
  int cur    = 0;
  bit done   = 0;

  int sin_tab [32] = '{0, 25, 49, 71, 90, 106, 117, 125, 127, 125, 117, 106, 90, 71, 49, 25,
                       0, -25, -49, -71, -90, -106, -117, -125, -127, -125, -117, -106, -90, -71, -49, -25};

  always #4 clk = ~clk;

  dtmf_synth dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .code_i       (code),
    .code_load_i  (load),
    .tone_en_i    (en),
    .single_i     (single),
    .col_sel_i    (csel),
    .row_sample_o (row_s),
    .col_sample_o (col_s),
    .sum_o        (sum_s)
  );

  function automatic int row_len(input int c);
    case (c)
      1, 2, 3, 13:   return 160;
      4, 5, 6, 14:   return 146;
      7, 8, 9, 15:   return 132;
      default:       return 118;
    endcase
  endfunction

  function automatic int col_len(input int c);
    case (c)
      1, 4, 7, 11:   return 92;
      2, 5, 8, 10:   return 84;
      3, 6, 9, 12:   return 76;
      default:       return 68;
    endcase
  endfunction

  task automatic check(input string tag);
    int er, ec, es;
    er = (en && !(single && csel))  ? sin_tab[(t / row_len(cur)) % 32] : 0;
    ec = (en && !(single && !csel)) ? sin_tab[(t / col_len(cur)) % 32] : 0;
    es = er + ec;
    n_vec++;
    if (int'(row_s) != er || int'(col_s) != ec || int'(sum_s) != es) begin
      n_fail++;
      $display("FAIL %s code=%0d t=%0d: row=%0d col=%0d sum=%0d expected row=%0d col=%0d sum=%0d",
               tag, cur, t, row_s, col_s, sum_s, er, ec, es);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    t += n;
  endtask

  task automatic load_code(input int c);
    code = 4'(c);
    load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    cur  = c;
    t    = 0;
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    n_vec++;
    if (row_s != 0 || col_s != 0 || sum_s != 0) begin
      n_fail++;
      $display("FAIL R10 in reset: row=%0d col=%0d sum=%0d expected 0 0 0", row_s, col_s, sum_s);
    end
    rst_n = 1'b1;
    cur = 0;
    t = 0;
    check("R10");
    step(67);  check("R10");
    step(1);   check("R10");
    step(49);  check("R10");
    step(1);   check("R10");
  endtask

  task automatic test_map;
    for (int c = 0; c < 16; c++) begin
      load_code(c);
      step(col_len(c) - 1);              check("R1 R3");
      step(1);                           check("R1 R3");
      step(row_len(c) - col_len(c) - 1); check("R1 R2");
      step(1);                           check("R1 R2");
    end
  endtask

  task automatic test_period;
    load_code(1);
    for (int k = 0; k < 33; k++) begin
      check("R4 R5");
      step(160);
    end
  endtask

  task automatic test_restart;
    load_code(5);
    step(300); check("R6");
    load_code(5);
    check("R6");
    step(83);  check("R6");
    step(1);   check("R6");
    load_code(12);
    step(75);  check("R6");
    step(1);   check("R6");
  endtask

  task automatic test_enable;
    en = 1'b0;
    load_code(9);
    check("R7");
    step(200); check("R7");
    en = 1'b1;
    #1; check("R7");
    step(50); check("R7");
  endtask

  task automatic test_single;
    load_code(6);
    step(400);
    single = 1'b1; csel = 1'b0;
    #1; check("R8");
    step(60); check("R8");
    csel = 1'b1;
    #1; check("R8");
    step(60); check("R8");
    single = 1'b0; csel = 1'b0;
    #1; check("R8");
  endtask

  task automatic test_scan;
    load_code(13);
    for (int i = 0; i < 6000; i++) begin
      step(1);
      check("R9");
    end
  endtask

  initial begin
    test_reset();
    test_map();
    test_period();
    test_restart();
    test_enable();
    test_single();
    test_scan();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule